// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block models the status pins of a parallel NOR flash while an internal program or erase sequence runs. A command front end, which lives elsewhere, reports each event as a one-cycle pulse: program start, erase start with a sector-select mask, suspend, resume and operation done. The block then produces the two toggle bits and the open-drain ready/busy indication on every read. Array contents come in on `arr_data`. The block passes them through whenever a read is not a status read.

The first toggle bit sits on bit 6. It flips after each completed read while any operation is active. The second toggle bit sits on bit 2. It flips only for reads inside sectors that are being erased, and it keeps doing so while the erase is suspended. When a program targets a protected sector, or an erase selects only protected sectors, there is no real operation. Instead the block runs a fixed-length pretend-busy window measured in clock cycles, and then returns to array reads by itself.

Top module: `flash_status_gen`

## Requirements
- R1: After reset the block is idle: `ryby_pull` is 0 and a read returns `arr_data` unchanged.
- R2: From the cycle after an accepted program or erase start until the cycle after `op_done`, `ryby_pull` is 1. After that, reads return `arr_data` again.
- R3: A read is active when `ce_n` and `oe_n` are both low. A status read returns bit 6 = first toggle bit, bit 2 = second toggle bit, and 0 on bit 5 and on every other bit. While an operation is active, bit 6 inverts after each read ends, whether `ce_n` or `oe_n` ends the read.
- R4: During erase suspend, `ryby_pull` is 0 and bit 6 stays frozen. Reads in erasing sectors return status. Reads in other sectors return `arr_data`.
- R5: The sector is `addr[ADDR_W-1 -: SEC_BITS]`. Bit 2 inverts after a read of an erasing sector during erase, suspend or suspended program. Reads of any other sector leave it unchanged.
- R6: A program start during suspend makes the block busy with bit 6 toggling. `op_done` then returns it to suspend, with `ryby_pull` back at 0.
- R7: `resume_req` during suspend returns the block to active erase: busy, with bit 6 toggling.
- R8: A program start aimed at a protected sector gives exactly CLK_MHZ*PROG_US busy cycles, with bit 6 toggling on reads, and then returns to idle without `op_done`.
- R9: An erase start whose selected sectors are all protected gives exactly CLK_MHZ*ERASE_US busy cycles, and then returns to idle.
- R10: With partial protection, only the selected unprotected sectors count as erasing for bit 2.
- R11: Start events that arrive while an operation is busy are ignored.
- R12: When no read is active, `dq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Read or program address |
| arr_data | input | 8 | Array data for non-status reads |
| prog_start | input | 1 | Program command accepted (pulse) |
| erase_start | input | 1 | Erase command accepted (pulse) |
| erase_sel | input | 2**SEC_BITS | Sectors selected for erase |
| suspend_req | input | 1 | Erase suspend (pulse) |
| resume_req | input | 1 | Erase resume (pulse) |
| op_done | input | 1 | Real operation finished (pulse) |
| prot_mask | input | 2**SEC_BITS | Protected sectors |
| dq | output | 8 | Read data |
| ryby_pull | output | 1 | 1 = pull ready/busy line low (busy) |

## Verification
The bench follows a full erase with partial protection and checks that the protected selected sector never flips bit 2. A design that used the raw select mask would flip it. In suspend it checks that bit 6 freezes while bit 2 keeps flipping, and that other sectors read array data. A design that tied the two bits together, or served status everywhere, would fail those checks. The bench measures both pretend-busy windows to the exact cycle, which catches an off-by-one counter. It frames reads with each strobe in turn, which catches a design that watches only one of them.

// File: rtl/flash_status_gen.sv
`timescale 1ns/1ps
module flash_status_gen #(
  parameter int ADDR_W   = 12,
  parameter int SEC_BITS = 3,
  parameter int CLK_MHZ  = 200,
  parameter int PROG_US  = 1,
  parameter int ERASE_US = 100,
  localparam int NSEC    = 2**SEC_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        arr_data,
  input  logic              prog_start,
  input  logic              erase_start,
  input  logic [NSEC-1:0]   erase_sel,
  input  logic              suspend_req,
  input  logic              resume_req,
  input  logic              op_done,
  input  logic [NSEC-1:0]   prot_mask,
  output logic [7:0]        dq,
  output logic              ryby_pull
);
  localparam int PROG_CYC  = CLK_MHZ * PROG_US;
  localparam int ERASE_CYC = CLK_MHZ * ERASE_US;
  localparam int MAXC      = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW        = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PROG, S_ERASE, S_SUSP, S_SPROG, S_FPROG, S_FERASE, S_FSPROG
  } st_t;

  st_t st, st_n;
  logic [CW-1:0]       cnt, cnt_n;
  logic [NSEC-1:0]     sel, sel_n;
  logic                rd, rd_q, t6, t2;
  logic [SEC_BITS-1:0] sec, sec_q;

  assign rd  = !ce_n && !oe_n;
  assign sec = addr[ADDR_W-1 -: SEC_BITS];

  wire [NSEC-1:0] live    = erase_sel & ~prot_mask;
  wire            tgt_prot = prot_mask[sec];
  wire            busy    = st inside {S_PROG, S_ERASE, S_SPROG, S_FPROG, S_FERASE, S_FSPROG};
  wire            erasing = st inside {S_ERASE, S_SUSP, S_SPROG};
  wire            rd_end  = rd_q && !rd;
  wire            status  = busy || (st == S_SUSP && sel[sec]);

  assign dq        = !rd ? 8'h00 : status ? {1'b0, t6, 1'b0, 2'b00, t2, 2'b00} : arr_data;
  assign ryby_pull = busy;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    sel_n = sel;
    case (st)
      S_IDLE:
        if (prog_start) begin
          if (tgt_prot) begin
            st_n  = S_FPROG;
            cnt_n = CW'(PROG_CYC - 1);
          end else st_n = S_PROG;
        end else if (erase_start) begin
          if (live == '0) begin
            st_n  = S_FERASE;
            cnt_n = CW'(ERASE_CYC - 1);
            sel_n = '0;
          end else begin
            st_n  = S_ERASE;
            sel_n = live;
          end
        end
      S_PROG:
        if (op_done) st_n = S_IDLE;
      S_ERASE:
        if (op_done) begin
          st_n  = S_IDLE;
          sel_n = '0;
        end else if (suspend_req) st_n = S_SUSP;
      S_SUSP:
        if (resume_req) st_n = S_ERASE;
        else if (prog_start) begin
          if (tgt_prot) begin
            st_n  = S_FSPROG;
            cnt_n = CW'(PROG_CYC - 1);
          end else st_n = S_SPROG;
        end
      S_SPROG:
        if (op_done) st_n = S_SUSP;
      S_FPROG, S_FERASE, S_FSPROG:
        if (cnt == '0) st_n = (st == S_FSPROG) ? S_SUSP : S_IDLE;
        else cnt_n = cnt - 1'b1;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      sel   <= '0;
      rd_q  <= 1'b0;
      sec_q <= '0;
      t6    <= 1'b0;
      t2    <= 1'b0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      sel  <= sel_n;
      rd_q <= rd;
      if (rd) sec_q <= sec;
      if (rd_end && busy) t6 <= !t6;
      if (rd_end && erasing && sel[sec_q]) t2 <= !t2;
    end
  end
endmodule

module flash_status_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] st,
  input logic       rd,
  input logic       rd_q,
  input logic       t6,
  input logic       ryby_pull,
  input logic [7:0] dq,
  input logic       prog_start,
  input logic       op_done,
  input logic       tgt_prot
);
  assert_prog_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && prog_start) |=> ryby_pull);
  assert_done_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd1 && op_done) |=> !ryby_pull);
  assert_dq6_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_q && !rd) |=> $stable(t6));
  assert_susp_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3) |=> $stable(t6));
  assert_susp_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3) |-> !ryby_pull);
  assert_prot_prog_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && prog_start && tgt_prot) |=> (ryby_pull && st == 3'd5));
  assert_idle_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> dq == 8'h00);
endmodule

bind flash_status_gen flash_status_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .rd(rd), .rd_q(rd_q), .t6(t6),
  .ryby_pull(ryby_pull), .dq(dq), .prog_start(prog_start), .op_done(op_done),
  .tgt_prot(tgt_prot)
);

// File: tb/flash_status_gen_bench.sv
`timescale 1ns/1ps
module flash_status_gen_bench;
  localparam int ADDR_W = 12, SEC_BITS = 3, CLK_MHZ = 8;
  localparam int PROG_CYC = CLK_MHZ * 1, ERASE_CYC = CLK_MHZ * 100;

  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] arr_data = '0, erase_sel = '0, prot_mask = '0;
  logic prog_start = 0, erase_start = 0, suspend_req = 0, resume_req = 0, op_done = 0;
  logic [7:0] dq;
  logic ryby_pull;

  flash_status_gen #(.ADDR_W(ADDR_W), .SEC_BITS(SEC_BITS), .CLK_MHZ(CLK_MHZ)) u_flash_status_gen (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .addr(addr), .arr_data(arr_data),
    .prog_start(prog_start), .erase_start(erase_start), .erase_sel(erase_sel),
    .suspend_req(suspend_req), .resume_req(resume_req), .op_done(op_done),
    .prot_mask(prot_mask), .dq(dq), .ryby_pull(ryby_pull));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  int bm = 0;          // 0 idle,1 prog,2 erase,3 susp,4 susp-prog,5 fake
  logic e6 = 0, e2 = 0;
  logic [7:0] esel = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] exp_dq(int m, logic [2:0] s, logic [7:0] a);
    logic st;
    st = (m != 0 && m != 3) || (m == 3 && esel[s]);
    return st ? {1'b0, e6, 1'b0, 2'b00, e2, 2'b00} : a;
  endfunction

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] s, input int how, input string r);
    logic [7:0] a;
    a = 8'($urandom);
    @(negedge clk);
    addr = {s, 9'($urandom)};
    arr_data = a;
    ce_n = 0; oe_n = 0;
    @(negedge clk);
    chk(r, dq, exp_dq(bm, s, a));
    if (how == 1) ce_n = 1;
    else if (how == 2) oe_n = 1;
    else begin ce_n = 1; oe_n = 1; end
    @(negedge clk);
    ce_n = 1; oe_n = 1;
    if (bm != 0 && bm != 3) e6 = ~e6;
    if ((bm == 2 || bm == 3 || bm == 4) && esel[s]) e2 = ~e2;
  endtask

  task automatic ev(input int which, input logic [2:0] s);
    @(negedge clk);
    addr = {s, 9'd0};
    case (which)
      0: prog_start = 1;
      1: erase_start = 1;
      2: suspend_req = 1;
      3: resume_req = 1;
      default: op_done = 1;
    endcase
    @(negedge clk);
    {prog_start, erase_start, suspend_req, resume_req, op_done} = '0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0;
    void'($urandom(32'd7));
    prot_mask = 8'b0010_1000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after reset", {7'd0, ryby_pull}, 8'd0);
    chk("R12 bus idle", dq, 8'h00);
    rd(3'd0, 0, "R1 idle read");

    ev(0, 3'd2); bm = 1;
    chk("R2 program busy", {7'd0, ryby_pull}, 8'd1);
    rd(3'd2, 0, "R3 both strobes");
    rd(3'd4, 1, "R3 ce framed");
    rd(3'd6, 2, "R3 oe framed");
    rd(3'd0, 0, "R3 toggle");
    erase_sel = 8'b0000_0010;
    ev(1, 3'd0);
    rd(3'd1, 0, "R11 erase ignored while busy");
    ev(4, 3'd0); bm = 0;
    chk("R2 release after done", {7'd0, ryby_pull}, 8'd0);
    rd(3'd1, 0, "R11 idle after done");

    erase_sel = 8'b0000_1010; esel = 8'b0000_0010;
    ev(1, 3'd0); bm = 2;
    chk("R2 erase busy", {7'd0, ryby_pull}, 8'd1);
    for (int i = 0; i < 40; i++) rd(3'($urandom), $urandom % 3, "R10 R5 erase reads");
    rd(3'd3, 0, "R10 protected selected"); rd(3'd3, 0, "R10 protected selected");
    rd(3'd1, 0, "R5 erasing sector"); rd(3'd1, 0, "R5 erasing sector");

    ev(2, 3'd0); bm = 3;
    chk("R4 suspend ready", {7'd0, ryby_pull}, 8'd0);
    for (int i = 0; i < 6; i++) rd(3'd1, 0, "R4 R5 suspended sector");
    rd(3'd2, 0, "R4 array outside"); rd(3'd5, 1, "R4 array outside");

    ev(0, 3'd2); bm = 4;
    chk("R6 suspend program busy", {7'd0, ryby_pull}, 8'd1);
    for (int i = 0; i < 10; i++) rd(3'($urandom), 0, "R6 suspend program reads");
    ev(4, 3'd0); bm = 3;
    chk("R6 back to suspend", {7'd0, ryby_pull}, 8'd0);
    rd(3'd1, 0, "R6 suspended again");

    ev(3, 3'd0); bm = 2;
    chk("R7 resume busy", {7'd0, ryby_pull}, 8'd1);
    rd(3'd0, 0, "R7 toggling again"); rd(3'd1, 0, "R7 toggling again");
    ev(4, 3'd0); bm = 0; esel = '0;
    chk("R2 erase done", {7'd0, ryby_pull}, 8'd0);

    ev(0, 3'd5); bm = 5; c0 = cyc;
    rd(3'd0, 0, "R8 fake program toggles"); rd(3'd2, 0, "R8 fake program toggles");
    while (cyc < c0 + PROG_CYC - 1) @(negedge clk);
    chk("R8 busy last cycle", {7'd0, ryby_pull}, 8'd1);
    @(negedge clk); bm = 0;
    chk("R8 idle after window", {7'd0, ryby_pull}, 8'd0);
    rd(3'd5, 0, "R8 array read");

    erase_sel = 8'b0010_1000;
    ev(1, 3'd0); bm = 5; c0 = cyc;
    rd(3'd3, 0, "R9 fake erase status"); rd(3'd5, 0, "R9 fake erase status");
    while (cyc < c0 + ERASE_CYC - 1) @(negedge clk);
    chk("R9 busy last cycle", {7'd0, ryby_pull}, 8'd1);
    @(negedge clk); bm = 0;
    chk("R9 idle after window", {7'd0, ryby_pull}, 8'd0);
    rd(3'd3, 0, "R9 array read");

    @(negedge clk);
    chk("R12 bus idle end", dq, 8'h00);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule